// File: doc/BRIEF.md
# Canary-Based Supply Self-Tuning Loop

This block is a closed-loop controller that finds the lowest safe supply setting for an embedded memory. After reset it reads a digitised clock-frequency value and picks a starting supply code and a set of peripheral assists from a small table indexed by that value. It then sweeps a small canary memory. The canary cells are deliberately weakened so that they fail before the main array does. Every canary address is written and read back, and the mismatches are counted.

The mismatch count is compared with a programmable failure threshold. While the canaries still pass, the controller requests one supply step down, waits a programmable settling time, and sweeps again. When the count reaches the threshold, the canary failure point has been found. The controller then steps the supply up once and reports that it is locked. The threshold is the knob that sets how close to failure the loop stops.

The voltage regulator, the frequency-to-digital converter and the canary array sit outside the block. The block drives the supply code, a one-cycle up or down request, the assist mask and the canary memory port. A change of the frequency code while the loop is locked starts the search again.

Top module: `canary_vmin_tuner`

## Requirements
- R1: The starting supply code is BASE + STEP × idx, where idx is the upper 3 bits of `freq_code` (defaults BASE=16, STEP=4). The value is clamped into [`vcode_min`, `vcode_max`] and appears on `vcode` once loaded.
- R2: The assist mask comes from idx[2:1]. The encoding is 0→3'b001, 1→3'b010, 2→3'b100 and 3→3'b101. Bit0 is negative bitline, bit1 is wordline boost and bit2 is supply boost.
- R3: A sweep visits canary addresses 0 to NADDR-1 in order. Each address gets a write cycle with data 8'hA5 XOR address, then a read cycle; the read data is expected on `cmem_rdata` one cycle after the read strobe. Each address whose read data differs from the written data adds one to the failure count.
- R4: If the failure count is below `fail_thresh` and `vcode` is above `vcode_min`, `vcode` drops by one with a one-cycle `v_dn` pulse, and another sweep follows.
- R5: If the failure count is at or above `fail_thresh` and `vcode` is below `vcode_max`, `vcode` rises by one with a one-cycle `v_up` pulse in the same cycle as `locked` rises.
- R6: If the failure count is below the threshold while `vcode` equals `vcode_min`, the loop locks with the code unchanged.
- R7: If the failure count is at or above the threshold while `vcode` equals `vcode_max`, `err` is raised, `locked` stays low and the code is held.
- R8: After a table load or a down step, no canary strobe is issued for `settle_cycles`+1 cycles. The first sweep write comes `settle_cycles`+1 cycles after the cycle in which `v_dn` is high.
- R9: While locked, any change of `freq_code` drops `locked` on the next cycle and restarts the search from the table value. An unchanged code keeps the lock.
- R10: During reset, `vcode`, `assist_mask`, `locked`, `err`, `v_up`, `v_dn`, `cmem_we` and `cmem_re` are all zero.
- R11: `v_up` and `v_dn` are never high together, and each pulse matches a one-step change of `vcode` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_code | input | 8 | Digitised clock frequency |
| fail_thresh | input | 5 | Canary failure count that marks the failure point |
| vcode_min | input | 6 | Lowest allowed supply code |
| vcode_max | input | 6 | Highest allowed supply code |
| settle_cycles | input | 8 | Settling wait after a supply change |
| cmem_rdata | input | 8 | Canary read data, one cycle after the read strobe |
| cmem_addr | output | 4 | Canary address |
| cmem_wdata | output | 8 | Canary write data |
| cmem_we | output | 1 | Canary write strobe |
| cmem_re | output | 1 | Canary read strobe |
| vcode | output | 6 | Supply code to the regulator |
| assist_mask | output | 3 | Enabled peripheral assists |
| v_up | output | 1 | One-cycle step-up request |
| v_dn | output | 1 | One-cycle step-down request |
| locked | output | 1 | Failure point found, supply settled |
| err | output | 1 | Canaries still failing at the maximum code |

## Verification
The bench models a canary array in which the number of failing addresses grows as the code drops below a chosen knee. It then checks the final code, mask, lock and error against values worked out by hand. Several cases are aimed at boundaries.

A count exactly equal to the threshold must step up. A design using a strict comparison would keep descending one step too far. A table value above `vcode_max` must be clamped and then flagged as an error. A design that skipped the clamp would issue an out-of-range code, and one that ignored the ceiling would lock at an illegal value. Reaching `vcode_min` while still passing must lock without a step; an unguarded decrement would wrap the code around.

The settling gap is measured in cycles, so an off-by-one in the timer shows up directly. A frequency change while locked must drop the lock at once and reach the new table's answer. A design that never compared the code would stay locked at the old setting.

// File: rtl/canary_tune_pkg.sv
package canary_tune_pkg;

  typedef enum logic [2:0] {
    ST_LOAD, ST_SETTLE, ST_SWEEP, ST_LOCK, ST_ERR
  } tune_st_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_WR, PH_RD, PH_CMP
  } sweep_ph_e;

  // starting code for one table slot
  function automatic int table_code(int idx, int base, int step);
    return base + idx * step;
  endfunction

  // assist selection: bit0 neg bitline, bit1 wordline boost, bit2 supply boost
  function automatic logic [2:0] table_assist(int idx);
    case (idx / 2)
      0:       return 3'b001;
      1:       return 3'b010;
      2:       return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic [31:0] canary_pattern(int addr);
    return 32'hA5A5_A5A5 ^ addr;
  endfunction

  function automatic int clamp_code(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/freq_table.sv
module freq_table
  import canary_tune_pkg::*;
#(
  parameter int FW   = 8,
  parameter int VW   = 6,
  parameter int IDXW = 3,
  parameter int BASE = 16,
  parameter int STEP = 4
) (
  input  logic [FW-1:0] freq_code,
  input  logic [VW-1:0] vmin,
  input  logic [VW-1:0] vmax,
  output logic [VW-1:0] init_code,
  output logic [2:0]    init_mask
);
  localparam int NENT = 1 << IDXW;

  logic [VW-1:0] code_tab [NENT];
  logic [2:0]    mask_tab [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    assign code_tab[i] = VW'(table_code(i, BASE, STEP));
    assign mask_tab[i] = table_assist(i);
  end

  logic [IDXW-1:0] idx;
  assign idx       = freq_code[FW-1 -: IDXW];
  assign init_code = VW'(clamp_code(int'(code_tab[idx]), int'(vmin), int'(vmax)));
  assign init_mask = mask_tab[idx];
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] cycles,
  output logic          busy,
  output logic          expire
);
  logic [SW-1:0] cnt;

  assign expire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= cycles;
      busy <= 1'b1;
    end else if (expire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/canary_sweeper.sv
module canary_sweeper
  import canary_tune_pkg::*;
#(
  parameter int NADDR = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NADDR),
  localparam int CW   = $clog2(NADDR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic          re,
  output logic          done,
  output logic [CW-1:0] fail_count
);
  localparam logic [AW-1:0] LAST = AW'(NADDR - 1);

  sweep_ph_e ph;
  logic      mismatch;

  assign wdata    = DW'(canary_pattern(int'(addr)));
  assign we       = (ph == PH_WR);
  assign re       = (ph == PH_RD);
  assign mismatch = (ph == PH_CMP) && (rdata != wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      addr       <= '0;
      fail_count <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          ph         <= PH_WR;
          addr       <= '0;
          fail_count <= '0;
        end
        PH_WR: ph <= PH_RD;
        PH_RD: ph <= PH_CMP;
        default: begin
          fail_count <= fail_count + CW'(mismatch);
          if (addr == LAST) begin
            ph   <= PH_IDLE;
            done <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
            ph   <= PH_WR;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/canary_vmin_tuner.sv
module canary_vmin_tuner
  import canary_tune_pkg::*;
#(
  parameter int FW    = 8,
  parameter int VW    = 6,
  parameter int SW    = 8,
  parameter int NADDR = 16,
  parameter int DW    = 8,
  parameter int BASE  = 16,
  parameter int STEP  = 4,
  localparam int AW   = $clog2(NADDR),
  localparam int CW   = $clog2(NADDR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] freq_code,
  input  logic [CW-1:0] fail_thresh,
  input  logic [VW-1:0] vcode_min,
  input  logic [VW-1:0] vcode_max,
  input  logic [SW-1:0] settle_cycles,
  input  logic [DW-1:0] cmem_rdata,
  output logic [AW-1:0] cmem_addr,
  output logic [DW-1:0] cmem_wdata,
  output logic          cmem_we,
  output logic          cmem_re,
  output logic [VW-1:0] vcode,
  output logic [2:0]    assist_mask,
  output logic          v_up,
  output logic          v_dn,
  output logic          locked,
  output logic          err
);
  tune_st_e      st;
  logic [FW-1:0] freq_held;
  logic [VW-1:0] init_code;
  logic [2:0]    init_mask;
  logic [CW-1:0] fail_count;

  // named internal events
  logic settle_busy, settle_expire, sweep_done, load_evt, timer_load;
  logic below_thresh, at_floor, at_ceiling, freq_moved;

  assign load_evt     = (st == ST_LOAD);
  assign below_thresh = fail_count < fail_thresh;
  assign at_floor     = vcode <= vcode_min;
  assign at_ceiling   = vcode >= vcode_max;
  assign freq_moved   = freq_code != freq_held;
  assign timer_load   = load_evt ||
                        ((st == ST_SWEEP) && sweep_done && below_thresh && !at_floor);

  freq_table #(.FW(FW), .VW(VW), .IDXW(3), .BASE(BASE), .STEP(STEP)) u_table (
    .freq_code(freq_code), .vmin(vcode_min), .vmax(vcode_max),
    .init_code(init_code), .init_mask(init_mask)
  );

  settle_timer #(.SW(SW)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .cycles(settle_cycles),
    .busy(settle_busy), .expire(settle_expire)
  );

  canary_sweeper #(.NADDR(NADDR), .DW(DW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start((st == ST_SETTLE) && settle_expire),
    .rdata(cmem_rdata), .addr(cmem_addr), .wdata(cmem_wdata),
    .we(cmem_we), .re(cmem_re), .done(sweep_done), .fail_count(fail_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_LOAD;
      freq_held   <= '0;
      vcode       <= '0;
      assist_mask <= '0;
      v_up        <= 1'b0;
      v_dn        <= 1'b0;
      locked      <= 1'b0;
      err         <= 1'b0;
    end else begin
      v_up <= 1'b0;
      v_dn <= 1'b0;
      case (st)
        ST_LOAD: begin
          vcode       <= init_code;
          assist_mask <= init_mask;
          freq_held   <= freq_code;
          locked      <= 1'b0;
          err         <= 1'b0;
          st          <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_expire) st <= ST_SWEEP;
        ST_SWEEP: if (sweep_done) begin
          if (below_thresh) begin
            if (!at_floor) begin
              vcode <= vcode - 1'b1;
              v_dn  <= 1'b1;
              st    <= ST_SETTLE;
            end else begin
              locked <= 1'b1;
              st     <= ST_LOCK;
            end
          end else if (!at_ceiling) begin
            vcode  <= vcode + 1'b1;
            v_up   <= 1'b1;
            locked <= 1'b1;
            st     <= ST_LOCK;
          end else begin
            err <= 1'b1;
            st  <= ST_ERR;
          end
        end
        default: if (freq_moved) begin
          locked <= 1'b0;
          st     <= ST_LOAD;
        end
      endcase
    end
  end
endmodule

// File: rtl/canary_vmin_tuner_chk.sv
module canary_vmin_tuner_chk #(
  parameter int VW = 6,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] vcode,
  input logic [VW-1:0] vcode_min,
  input logic [VW-1:0] vcode_max,
  input logic [FW-1:0] freq_code,
  input logic          v_up,
  input logic          v_dn,
  input logic          locked,
  input logic          err,
  input logic          cmem_we,
  input logic          cmem_re,
  input logic          settle_busy
);
  // R11: requests exclusive
  p_updn_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(v_up && v_dn));

  // R4: down request matches a one-step drop
  p_dn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_dn) |-> vcode == $past(vcode) - 1'b1);

  // R5: up request matches a one-step rise and lock
  p_up_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_up) |-> (vcode == $past(vcode) + 1'b1) && locked);

  // R7: error excludes lock
  p_err_nolock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !locked);

  // R8: no canary access while settling
  p_quiet_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> !cmem_we && !cmem_re);

  // R3: one strobe at a time
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmem_we && cmem_re));

  // R1: locked code within the bounds
  p_lock_bounds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (vcode >= vcode_min) && (vcode <= vcode_max));

  // R9: lock with unchanged frequency holds the code
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $stable(freq_code)) |=> $stable(vcode));
endmodule

bind canary_vmin_tuner canary_vmin_tuner_chk #(.VW(VW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vcode(vcode), .vcode_min(vcode_min),
  .vcode_max(vcode_max), .freq_code(freq_code), .v_up(v_up), .v_dn(v_dn),
  .locked(locked), .err(err), .cmem_we(cmem_we), .cmem_re(cmem_re),
  .settle_busy(settle_busy)
);

// File: tb/canary_vmin_tuner_bench.sv
module canary_vmin_tuner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] freq_code = '0;
  logic [4:0] fail_thresh = 5'd4;
  logic [5:0] vcode_min = 6'd2, vcode_max = 6'd60;
  logic [7:0] settle_cycles = 8'd3;
  logic [7:0] cmem_rdata;
  logic [3:0] cmem_addr;
  logic [7:0] cmem_wdata;
  logic       cmem_we, cmem_re;
  logic [5:0] vcode;
  logic [2:0] assist_mask;
  logic       v_up, v_dn, locked, err;

  int tests = 0, fails = 0;
  int knee = 10;

  always #10 clk = ~clk;

  canary_vmin_tuner u_canary_vmin_tuner (
    .clk(clk), .rst_n(rst_n), .freq_code(freq_code), .fail_thresh(fail_thresh),
    .vcode_min(vcode_min), .vcode_max(vcode_max), .settle_cycles(settle_cycles),
    .cmem_rdata(cmem_rdata), .cmem_addr(cmem_addr), .cmem_wdata(cmem_wdata),
    .cmem_we(cmem_we), .cmem_re(cmem_re), .vcode(vcode), .assist_mask(assist_mask),
    .v_up(v_up), .v_dn(v_dn), .locked(locked), .err(err)
  );

  // canary array model: failing cells grow by 3 per step below the knee
  logic [7:0] mem [16];
  function automatic int nfail(int v, int k);
    if (v >= k) return 0;
    return ((k - v) * 3 > 16) ? 16 : (k - v) * 3;
  endfunction
  always_ff @(posedge clk) begin
    if (cmem_we) mem[cmem_addr] <= cmem_wdata;
    if (cmem_re)
      cmem_rdata <= mem[cmem_addr] ^ ((int'(cmem_addr) < nfail(int'(vcode), knee)) ? 8'h01 : 8'h00);
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!(locked || err) && n < 8000) begin
      @(negedge clk);
      n++;
    end
    check({req, " finished"}, int'(n < 8000), 1);
  endtask

  typedef struct packed {
    logic [7:0] freq;
    logic [4:0] thr;
    logic [5:0] vmin;
    logic [5:0] vmax;
    logic [5:0] knee;
    logic [5:0] exp_v;
    logic [2:0] exp_mask;
    logic       exp_err;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'h00, 5'd4,  6'd2,  6'd60, 6'd10, 6'd9,  3'b001, 1'b0}, // R4 R5 descent
    '{8'h60, 5'd1,  6'd2,  6'd60, 6'd20, 6'd20, 3'b010, 1'b0}, // R2 idx3
    '{8'hE0, 5'd16, 6'd2,  6'd60, 6'd40, 6'd35, 3'b101, 1'b0}, // R5 count equals threshold
    '{8'h80, 5'd4,  6'd30, 6'd60, 6'd10, 6'd30, 3'b100, 1'b0}, // R6 floor
    '{8'hA0, 5'd4,  6'd2,  6'd33, 6'd50, 6'd33, 3'b100, 1'b1}, // R1 R7 clamp and ceiling
    '{8'h3F, 5'd4,  6'd2,  6'd60, 6'd5,  6'd4,  3'b001, 1'b0}, // R1 idx1
    '{8'h40, 5'd4,  6'd2,  6'd60, 6'd26, 6'd25, 3'b010, 1'b0}  // R3 R5 first sweep fails
  };

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 vcode", int'(vcode), 0);
    check("R10 mask", int'(assist_mask), 0);
    check("R10 flags", int'({locked, err, v_up, v_dn, cmem_we, cmem_re}), 0);

    foreach (VEC[i]) begin
      rst_n = 1'b0;
      freq_code = VEC[i].freq; fail_thresh = VEC[i].thr;
      vcode_min = VEC[i].vmin; vcode_max = VEC[i].vmax; knee = int'(VEC[i].knee);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wait_done("R4");
      check("R4 R5 R6 final code", int'(vcode), int'(VEC[i].exp_v));
      check("R2 assist mask", int'(assist_mask), int'(VEC[i].exp_mask));
      check("R7 err", int'(err), int'(VEC[i].exp_err));
      check("R5 locked", int'(locked), int'(!VEC[i].exp_err));
    end

    // R1 table value visible after load (idx 6 -> 40)
    rst_n = 1'b0; freq_code = 8'hC0; vcode_min = 6'd2; vcode_max = 6'd60;
    fail_thresh = 5'd4; knee = 10;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 loaded code", int'(vcode), 40);

    // R8 settle gap
    rst_n = 1'b0; freq_code = 8'h00; settle_cycles = 8'd5;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      int n = 0;
      int g = 0;
      while (!v_dn && g < 2000) begin @(negedge clk); g++; end
      while (!cmem_we && n < 100) begin @(negedge clk); n++; end
      check("R8 settle gap", n, 6);
    end

    // R9 lock held, then restart on frequency change
    wait_done("R9");
    check("R9 first lock", int'(vcode), 9);
    repeat (50) @(negedge clk);
    check("R9 lock kept", int'(locked), 1);
    freq_code = 8'h60; fail_thresh = 5'd1; knee = 20;
    @(negedge clk);
    check("R9 lock dropped", int'(locked), 0);
    wait_done("R9");
    check("R9 new code", int'(vcode), 20);
    check("R9 new mask", int'(assist_mask), 3'b010);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule